// File: doc/BRIEF.md
# Six-Bit Microcontroller I/O Port with Bit Set/Clear

This block is the general-purpose I/O port of a small microcontroller. It holds six pins. Each pin has an output latch bit and a direction bit, and its input level is sampled. A CPU sits on the other side and talks to the port in instruction cycles. It marks the start of each cycle with one strobe and the end with another. During the start strobe it presents an operation, a bit index and write data.

Reads return the synchronized level on the pins, not the latch. The pins are sampled when a cycle starts, and latches change when the cycle ends. A bit set or clear works as a read-modify-write: it takes the sample of the whole port, changes one bit and writes all six bits back into the latch. An input-mode pin can therefore have its latch silently replaced by whatever level it carried at that moment. A power-on reset clears the latches. Any other reset keeps them. A flag records whether the last reset was caused by a wake-up on pin change.

Top module: `gpio_port`

## Requirements
- R1: Read data bits 7 and 6 are always 0. Bits 5..0 carry the six pins, with bit n belonging to pin n.
- R2: Every reset sets all six direction bits to 1 (input), so `pin_oe_o` is 0 in the cycle after a reset.
- R3: A read (op code 1) returns the synchronized pin level on `rdata_o` after the start-strobe edge. An input pin whose latch differs from its pin level reads as the pin level.
- R4: A full write (op code 2) loads `wdata_i[5:0]` into the output latch at the end-strobe edge. `pin_out_o` always shows the latch, and a pin is driven (`pin_oe_o` bit 1) exactly when its direction bit is 0.
- R5: Bit set (op code 3) and bit clear (op code 4) load the latch with the start-of-cycle sample of all six pins, with only the indexed bit forced to 1 or 0. An input pin's latch thus takes its sampled pin level.
- R6: Pins pass through a two-flop synchronizer and are sampled only at the start-strobe edge. A pin change after that edge does not alter the value read in that cycle. An operation that starts right after a latch write still sees the old pin level.
- R7: A reset with `por_i` high clears the latch to 0. A reset with `por_i` low leaves the latch unchanged.
- R8: `wake_flag_o` takes the value of `wake_rst_i` at each reset and holds it until the next reset.
- R9: A bit set or clear with index 6 or 7 changes no bit apart from the write-back of the sampled pins.
- R10: A direction write (op code 5) loads `wdata_i[5:0]` into the direction bits at the end strobe and leaves the latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| por_i | input | 1 | Reset is a power-on reset (clears latch) |
| wake_rst_i | input | 1 | Reset was caused by a wake-up on pin change |
| cyc_start_i | input | 1 | Instruction-cycle start strobe; captures operation and pin sample |
| cyc_end_i | input | 1 | Instruction-cycle end strobe; commits latch or direction write |
| op_i | input | 3 | 0 idle, 1 read, 2 write, 3 bit set, 4 bit clear, 5 direction write |
| bit_i | input | 3 | Bit index for set and clear |
| wdata_i | input | 8 | Write data for full write and direction write |
| rdata_o | output | 8 | Sampled pin levels, bits 7..6 zero |
| pin_in_i | input | 6 | Pin input levels |
| pin_out_o | output | 6 | Output latch value per pin |
| pin_oe_o | output | 6 | Per-pin output enable |
| wake_flag_o | output | 1 | Wake-up reset flag |

## Verification
The hardest case to reach is a latch going wrong through read-modify-write. It happens in two ways. In the first, an input pin's latch is overwritten by its external level and is only exposed once that pin is switched to output. In the second, two bit clears run back to back, and the second one samples a pin whose new latch value has not yet crossed the synchronizer. The stimulus models external drivers that follow `pin_oe_o` and `pin_out_o`, and it sets up both cases in turn. In the first case each step is followed by settle cycles. In the second case the two clears are issued with no gap. A final direction write makes the corrupted latch visible on the pins.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int PORT_W = 6;
    localparam int BUS_W  = 8;
    localparam int IDX_W  = 3;

    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_READ  = 3'd1,
        OP_WRITE = 3'd2,
        OP_BSET  = 3'd3,
        OP_BCLR  = 3'd4,
        OP_DIR   = 3'd5
    } port_op_e;

    typedef struct packed {
        port_op_e             op;
        logic [IDX_W-1:0]     idx;
        logic [BUS_W-1:0]     data;
    } port_req_t;

    // Replace one bit of a port word; indices beyond the port leave it as is.
    function automatic logic [PORT_W-1:0] put_bit(input logic [PORT_W-1:0] base,
                                                  input logic [IDX_W-1:0]  idx,
                                                  input logic              val);
        logic [PORT_W-1:0] res;
        res = base;
        for (int i = 0; i < PORT_W; i++) begin
            if (int'(idx) == i) res[i] = val;
        end
        return res;
    endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = gpio_port_pkg::PORT_W,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk_i) begin
                if (rst_i) chain_q[s] <= '0;
                else if (s == 0) chain_q[s] <= d_i;
                else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_cycle.sv
module gpio_cycle
    import gpio_port_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         cyc_start_i,
    input  port_req_t    req_i,
    input  logic [W-1:0] pins_sync_i,
    output port_req_t    req_o,
    output logic [W-1:0] sample_o
);
    port_req_t    req_q;
    logic [W-1:0] smp_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            req_q <= '{op: OP_IDLE, idx: '0, data: '0};
            smp_q <= '0;
        end else if (cyc_start_i) begin
            req_q <= req_i;
            smp_q <= pins_sync_i;
        end
    end

    assign req_o    = req_q;
    assign sample_o = smp_q;

    // R6
    sample_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !cyc_start_i |=> $stable(smp_q));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         por_i,
    input  logic         wake_rst_i,
    input  logic         cyc_end_i,
    input  port_req_t    req_i,
    input  logic [W-1:0] sample_i,
    output logic [W-1:0] latch_o,
    output logic [W-1:0] dir_o,
    output logic         wake_o
);
    logic [W-1:0] latch_q;
    logic [W-1:0] dir_q;
    logic         wake_q;
    logic [W-1:0] latch_nxt;
    logic         latch_we;

    always_comb begin
        latch_we  = 1'b0;
        latch_nxt = latch_q;
        if (cyc_end_i) begin
            unique case (req_i.op)
                OP_WRITE: begin latch_we = 1'b1; latch_nxt = req_i.data[W-1:0]; end
                OP_BSET:  begin latch_we = 1'b1; latch_nxt = put_bit(sample_i, req_i.idx, 1'b1); end
                OP_BCLR:  begin latch_we = 1'b1; latch_nxt = put_bit(sample_i, req_i.idx, 1'b0); end
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            if (por_i) latch_q <= '0;
        end else if (latch_we) begin
            latch_q <= latch_nxt;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            dir_q  <= '1;
            wake_q <= wake_rst_i;
        end else if (cyc_end_i && req_i.op == OP_DIR) begin
            dir_q <= req_i.data[W-1:0];
        end
    end

    assign latch_o = latch_q;
    assign dir_o   = dir_q;
    assign wake_o  = wake_q;

    // R2
    dir_reset_chk: assert property (@(posedge clk_i)
        rst_i |=> (dir_q == {W{1'b1}}));
    // R5
    bclr_bit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (cyc_end_i && req_i.op == OP_BCLR && int'(req_i.idx) < W)
        |=> ((latch_q & ({{(W-1){1'b0}}, 1'b1} << $past(req_i.idx))) == '0));
    // R10
    dir_keeps_latch_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (cyc_end_i && req_i.op == OP_DIR) |=> $stable(latch_q));
    // R8
    wake_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> $stable(wake_q));
    // R7
    warm_reset_latch_chk: assert property (@(posedge clk_i)
        (rst_i && !por_i) |=> $stable(latch_q));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              por_i,
    input  logic              wake_rst_i,
    input  logic              cyc_start_i,
    input  logic              cyc_end_i,
    input  logic [2:0]        op_i,
    input  logic [IDX_W-1:0]  bit_i,
    input  logic [BUS_W-1:0]  wdata_i,
    output logic [BUS_W-1:0]  rdata_o,
    input  logic [PORT_W-1:0] pin_in_i,
    output logic [PORT_W-1:0] pin_out_o,
    output logic [PORT_W-1:0] pin_oe_o,
    output logic              wake_flag_o
);
    localparam int PAD_W = BUS_W - PORT_W;

    port_req_t         req_in;
    port_req_t         req_cur;
    logic [PORT_W-1:0] pins_sync;
    logic [PORT_W-1:0] sample;
    logic [PORT_W-1:0] latch;
    logic [PORT_W-1:0] dir;

    assign req_in = '{op: port_op_e'(op_i), idx: bit_i, data: wdata_i};

    gpio_sync #(.W(PORT_W), .STAGES(2)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (pin_in_i),
        .q_o   (pins_sync)
    );

    gpio_cycle #(.W(PORT_W)) u_cycle (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .cyc_start_i (cyc_start_i),
        .req_i       (req_in),
        .pins_sync_i (pins_sync),
        .req_o       (req_cur),
        .sample_o    (sample)
    );

    gpio_regs #(.W(PORT_W)) u_regs (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .por_i      (por_i),
        .wake_rst_i (wake_rst_i),
        .cyc_end_i  (cyc_end_i),
        .req_i      (req_cur),
        .sample_i   (sample),
        .latch_o    (latch),
        .dir_o      (dir),
        .wake_o     (wake_flag)
    );

    logic wake_flag;
    assign wake_flag_o = wake_flag;
    assign rdata_o     = {{PAD_W{1'b0}}, sample};
    assign pin_out_o   = latch;
    assign pin_oe_o    = ~dir;

    // R2
    oe_after_reset_chk: assert property (@(posedge clk_i)
        rst_i |=> (pin_oe_o == '0));
    // R8
    wake_capture_chk: assert property (@(posedge clk_i)
        rst_i |=> (wake_flag_o == $past(wake_rst_i)));
endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1, por = 1'b1, wake = 1'b0;
    logic       start = 1'b0, fin = 1'b0;
    logic [2:0] op = 3'd0, idx = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic [5:0] pin_in, pin_out, pin_oe;
    logic [5:0] ext_lvl = 6'b010101;
    logic       wflag;

    always #5 clk = ~clk;

    // external drivers: a pin follows the port when enabled, else the outside level
    assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext_lvl);

    gpio_port u_dut (
        .clk_i(clk), .rst_i(rst), .por_i(por), .wake_rst_i(wake),
        .cyc_start_i(start), .cyc_end_i(fin), .op_i(op), .bit_i(idx),
        .wdata_i(wdata), .rdata_o(rdata), .pin_in_i(pin_in),
        .pin_out_o(pin_out), .pin_oe_o(pin_oe), .wake_flag_o(wflag)
    );

    int n_chk = 0, n_fail = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];
    bit         done = 1'b0;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: each read is compared after its start edge
    always @(posedge clk) begin
        if (start && op == 3'd1) begin
            #1;
            if (exp_q.size() > 0) check(tag_q.pop_front(), rdata, exp_q.pop_front());
        end
    end

    task automatic run_op(input logic [2:0] o, input logic [2:0] b, input logic [7:0] d, input int settle);
        @(negedge clk); start = 1'b1; op = o; idx = b; wdata = d;
        @(negedge clk); start = 1'b0; fin = 1'b1;
        @(negedge clk); fin = 1'b0; op = 3'd0;
        repeat (settle) @(negedge clk);
    endtask

    task automatic read_exp(input string tag, input logic [7:0] e, input int settle);
        exp_q.push_back(e); tag_q.push_back(tag);
        run_op(3'd1, 3'd0, 8'h00, settle);
    endtask

    task automatic do_reset(input logic p, input logic w);
        @(negedge clk); rst = 1'b1; por = p; wake = w;
        @(negedge clk); rst = 1'b0; por = 1'b0; wake = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
        finish_run();
    end

    initial begin
        do_reset(1'b1, 1'b0);
        check("R2 oe after reset", {2'b0, pin_oe}, 8'h00);
        check("R8 flag after cold reset", {7'b0, wflag}, 8'h00);
        check("R7 latch cleared", {2'b0, pin_out}, 8'h00);
        read_exp("R3 input pins", 8'h15, 0);
        ext_lvl = 6'h3F; repeat (3) @(negedge clk);
        read_exp("R1 upper bits zero", 8'h3F, 0);

        // R4: latch written while pins are inputs
        run_op(3'd2, 3'd0, 8'hEA, 3);
        check("R4 latch shown", {2'b0, pin_out}, 8'h2A);
        check("R4 still released", {2'b0, pin_oe}, 8'h00);
        read_exp("R3 pin not latch", 8'h3F, 0);
        run_op(3'd5, 3'd0, 8'hC0, 3);
        check("R10 dir enables", {2'b0, pin_oe}, 8'h3F);
        check("R10 latch kept", {2'b0, pin_out}, 8'h2A);
        read_exp("R4 driven pins", 8'h2A, 0);

        // R6: read right after a write sees the old level
        run_op(3'd2, 3'd0, 8'h3F, 3);
        run_op(3'd2, 3'd0, 8'h00, 0);
        read_exp("R6 stale after write", 8'h3F, 3);
        read_exp("R6 settled", 8'h00, 0);

        // R6: change after start edge does not alter the read
        run_op(3'd5, 3'd0, 8'h3F, 0);
        ext_lvl = 6'h00; repeat (3) @(negedge clk);
        exp_q.push_back(8'h00); tag_q.push_back("R6 sample at start");
        @(negedge clk); start = 1'b1; op = 3'd1;
        @(negedge clk); start = 1'b0; fin = 1'b1; ext_lvl = 6'h3F;
        @(negedge clk); fin = 1'b0; op = 3'd0;
        check("R6 held through cycle", rdata, 8'h00);
        repeat (3) @(negedge clk);
        read_exp("R6 new level next cycle", 8'h3F, 0);

        // R5: input pin latch overwritten by read-modify-write
        ext_lvl = 6'h01;
        run_op(3'd5, 3'd0, 8'h01, 3);
        run_op(3'd2, 3'd0, 8'h30, 3);
        run_op(3'd4, 3'd5, 8'h00, 3);
        run_op(3'd4, 3'd4, 8'h00, 3);
        check("R5 input latch rewritten", {2'b0, pin_out}, 8'h01);
        run_op(3'd5, 3'd0, 8'h00, 3);
        read_exp("R5 corrupted pin driven", 8'h01, 0);

        // R6: back-to-back clears, second samples unsettled pin
        run_op(3'd2, 3'd0, 8'h30, 3);
        run_op(3'd4, 3'd5, 8'h00, 0);
        run_op(3'd4, 3'd4, 8'h00, 3);
        check("R6 back-to-back clear", {2'b0, pin_out}, 8'h20);
        run_op(3'd3, 3'd2, 8'h00, 3);
        check("R5 bit set", {2'b0, pin_out}, 8'h24);

        // R9: out-of-range indices
        run_op(3'd3, 3'd6, 8'h00, 3);
        check("R9 set index 6", {2'b0, pin_out}, 8'h24);
        run_op(3'd4, 3'd7, 8'h00, 3);
        check("R9 clear index 7", {2'b0, pin_out}, 8'h24);

        // R7/R8: reset kinds
        do_reset(1'b0, 1'b0);
        check("R7 warm reset keeps latch", {2'b0, pin_out}, 8'h24);
        check("R2 warm reset releases", {2'b0, pin_oe}, 8'h00);
        do_reset(1'b0, 1'b1);
        check("R8 wake flag set", {7'b0, wflag}, 8'h01);
        run_op(3'd2, 3'd0, 8'h11, 3);
        check("R8 flag holds", {7'b0, wflag}, 8'h01);
        do_reset(1'b0, 1'b0);
        check("R8 flag cleared", {7'b0, wflag}, 8'h00);
        check("R7 latch after warm", {2'b0, pin_out}, 8'h11);
        do_reset(1'b1, 1'b0);
        check("R7 cold reset clears", {2'b0, pin_out}, 8'h00);

        finish_run();
    end
endmodule